// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records an on-chip trace stream into a circular RAM so that software can read it back later. Trace arrives one byte lane at a time. A packer gathers the lanes into 32-bit words. While capture is enabled, each finished word is stored at the write pointer, and the pointer then advances modulo the buffer depth. When the write pointer wraps, a sticky full flag is set. From then on the buffer holds a complete window, and the oldest word sits at the write pointer.

Software uses a 32-bit register port. The usual sequence is: disable capture, request a manual flush so that a partly packed word is written into the RAM, set the read pointer to the oldest word, and drain the buffer through a data register. Each read of that register advances the read pointer. A keyed lock blocks every register write except a write to the lock register itself. Reads are allowed at all times.

Top module: `trace_buf_top`

## Requirements
- R1: After reset the block reads back as follows: read pointer, write pointer, trigger count, capture enable, status and formatter control are all 0, the depth register reads DEPTH, and lock status reads 3 (bit 0 = lock implemented, bit 1 = locked).
- R2: A write to 0xFB0 with 0xC5ACCE55 unlocks the block. A write there with any other value locks it. While locked, writes to all other registers are ignored.
- R3: Trace bytes are taken only while capture enable (0x20 bit 0) is 1. The first byte of a word goes to bits 7:0, the next to 15:8, and so on.
- R4: Each completed word is written at the write pointer (0x18). The write pointer then increments, wrapping from DEPTH-1 to 0.
- R5: Status bit 0 (0x0C) is set when a word is written at address DEPTH-1. It stays set through pointer writes and through clearing capture enable.
- R6: Writing capture enable to 1 while it is 0 clears the full flag.
- R7: A read of 0x10 returns the word at the read pointer and then advances the read pointer by one, wrapping at DEPTH.
- R8: The read pointer (0x14), write pointer and trigger count (0x1C) are writable and read back. The pointers keep only log2(DEPTH) bits. The trigger count keeps 32 bits.
- R9: Writing bit 6 of 0x304 starts a flush. If a partial word is pending, it is written at the write pointer, padded with zeros. Bit 6 then reads 1 for exactly FLUSH_CYC cycles and then reads 0. If nothing is pending, the write pointer does not change.
- R10: A byte that arrives in the same cycle as a flush request is included in the flushed word.
- R11: 0x304 stores and returns bits 0, 1, 4, 8, 9 and 10. All other bits except the flush bit read 0.
- R12: If software writes the write pointer in the same cycle that a packed word is stored, the word goes to the old pointer and the written value wins.
- R13: Read data appears on reg_rdata_o one cycle after the request and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe, one per cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| trc_valid_i | input | 1 | Trace byte valid |
| trc_data_i | input | LANE_W | Trace byte |

## Verification
Two pairs of functions can collide in a single cycle. A flush request can arrive with a trace byte, and a software write of the write pointer can coincide with the packer storing a word. The bench provokes each collision by driving the byte and the register write on the same clock edge. For the flush, it checks that the flushed word holds both bytes. For the pointer write, it reads the old slot through the data port and checks that it holds the new word, while the write pointer reads back the value software wrote. Random byte, enable, flush and drain traffic runs against a bench model that tracks the full flag across wraps.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
  localparam logic [31:0] FMT_KEEP   = 32'h0000_0713;
  localparam int unsigned FLUSH_BIT  = 6;

  typedef enum logic [REG_AW-1:0] {
    A_DEPTH = 12'h004,
    A_STAT  = 12'h00C,
    A_DATA  = 12'h010,
    A_RDP   = 12'h014,
    A_WRP   = 12'h018,
    A_TRIG  = 12'h01C,
    A_CTRL  = 12'h020,
    A_FMT   = 12'h304,
    A_LOCK  = 12'hFB0,
    A_LSTAT = 12'hFB4
  } reg_addr_e;
endpackage

// File: rtl/trc_packer.sv
module trc_packer #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned LANES = WORD_W / LANE_W,
  localparam int unsigned CW    = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lane_valid_i,
  input  logic [LANE_W-1:0] lane_data_i,
  input  logic              flush_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic [LANES-1:0][LANE_W-1:0] lanes_q, lanes_n;
  logic [CW-1:0]                cnt_q, cnt_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      lanes_n[l] = lanes_q[l];
      if (lane_valid_i && cnt_q == CW'(l)) lanes_n[l] = lane_data_i;
    end
  end

  always_comb begin
    cnt_n        = cnt_q + CW'(lane_valid_i);
    word_valid_o = (cnt_n == CW'(LANES)) || (flush_i && cnt_n != '0);
    word_o       = lanes_n;  // lanes above the count are still zero
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lanes_q <= '0;
      cnt_q   <= '0;
    end else if (word_valid_o) begin
      lanes_q <= '0;
      cnt_q   <= '0;
    end else begin
      lanes_q <= lanes_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/trc_regs.sv
module trc_regs
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned FLUSH_CYC = 4,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned FCW      = $clog2(FLUSH_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              word_valid_i,
  input  logic [31:0]       ram_rdata_i,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_waddr_o,
  output logic [AW-1:0]     ram_raddr_o,
  output logic              cap_en_o,
  output logic              flush_req_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic [AW-1:0]     rd_ptr_o,
  output logic              full_o,
  output logic              locked_o,
  output logic              flush_busy_o
);
  logic           locked_q, en_q, full_q;
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [31:0]    trig_q, fmt_q;
  logic [FCW-1:0] flush_cnt_q;
  logic           wr_en, rd_en, en_rise, flush_busy;

  assign wr_en       = reg_valid_i && reg_write_i && !locked_q;
  assign rd_en       = reg_valid_i && !reg_write_i;
  assign en_rise     = wr_en && reg_addr_i == A_CTRL && reg_wdata_i[0] && !en_q;
  assign flush_req_o = wr_en && reg_addr_i == A_FMT && reg_wdata_i[FLUSH_BIT];
  assign flush_busy  = flush_cnt_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q    <= 1'b1;
      en_q        <= 1'b0;
      full_q      <= 1'b0;
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      trig_q      <= '0;
      fmt_q       <= '0;
      flush_cnt_q <= '0;
    end else begin
      if (reg_valid_i && reg_write_i && reg_addr_i == A_LOCK)
        locked_q <= reg_wdata_i != UNLOCK_KEY;
      if (wr_en && reg_addr_i == A_CTRL) en_q <= reg_wdata_i[0];
      if (wr_en && reg_addr_i == A_TRIG) trig_q <= reg_wdata_i;
      if (wr_en && reg_addr_i == A_FMT) fmt_q <= reg_wdata_i & FMT_KEEP;

      if (flush_req_o)     flush_cnt_q <= FCW'(FLUSH_CYC);
      else if (flush_busy) flush_cnt_q <= flush_cnt_q - 1'b1;

      // software pointer write beats the capture increment
      if (wr_en && reg_addr_i == A_WRP) wr_ptr_q <= reg_wdata_i[AW-1:0];
      else if (word_valid_i)            wr_ptr_q <= wr_ptr_q + 1'b1;

      if (wr_en && reg_addr_i == A_RDP)      rd_ptr_q <= reg_wdata_i[AW-1:0];
      else if (rd_en && reg_addr_i == A_DATA) rd_ptr_q <= rd_ptr_q + 1'b1;

      if (word_valid_i && wr_ptr_q == AW'(DEPTH - 1)) full_q <= 1'b1;
      else if (en_rise)                               full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o <= '0;
    end else if (rd_en) begin
      case (reg_addr_i)
        A_DEPTH: reg_rdata_o <= 32'(DEPTH);
        A_STAT:  reg_rdata_o <= {31'b0, full_q};
        A_DATA:  reg_rdata_o <= ram_rdata_i;
        A_RDP:   reg_rdata_o <= 32'(rd_ptr_q);
        A_WRP:   reg_rdata_o <= 32'(wr_ptr_q);
        A_TRIG:  reg_rdata_o <= trig_q;
        A_CTRL:  reg_rdata_o <= {31'b0, en_q};
        A_FMT:   reg_rdata_o <= fmt_q | (32'(flush_busy) << FLUSH_BIT);
        A_LSTAT: reg_rdata_o <= {30'b0, locked_q, 1'b1};
        default: reg_rdata_o <= '0;
      endcase
    end
  end

  assign ram_we_o     = word_valid_i;
  assign ram_waddr_o  = wr_ptr_q;
  assign ram_raddr_o  = rd_ptr_q;
  assign cap_en_o     = en_q;
  assign wr_ptr_o     = wr_ptr_q;
  assign rd_ptr_o     = rd_ptr_q;
  assign full_o       = full_q;
  assign locked_o     = locked_q;
  assign flush_busy_o = flush_busy;
endmodule

// File: rtl/trace_buf_top.sv
module trace_buf_top
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned FLUSH_CYC = 4,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              trc_valid_i,
  input  logic [LANE_W-1:0] trc_data_i
);
  logic          cap_en, flush_req, word_valid, ram_we;
  logic [31:0]   word, ram_rdata;
  logic [AW-1:0] ram_waddr, ram_raddr, wr_ptr, rd_ptr;
  logic          full, locked, flush_busy;

  trc_packer #(.LANE_W(LANE_W), .WORD_W(32)) u_pack (
    .clk_i, .rst_ni,
    .lane_valid_i (trc_valid_i && cap_en),
    .lane_data_i  (trc_data_i),
    .flush_i      (flush_req),
    .word_valid_o (word_valid),
    .word_o       (word)
  );

  trc_ram #(.DEPTH(DEPTH), .WORD_W(32)) u_ram (
    .clk_i,
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (word),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

  trc_regs #(.DEPTH(DEPTH), .FLUSH_CYC(FLUSH_CYC)) u_regs (
    .clk_i, .rst_ni,
    .reg_valid_i, .reg_write_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .word_valid_i (word_valid),
    .ram_rdata_i  (ram_rdata),
    .ram_we_o     (ram_we),
    .ram_waddr_o  (ram_waddr),
    .ram_raddr_o  (ram_raddr),
    .cap_en_o     (cap_en),
    .flush_req_o  (flush_req),
    .wr_ptr_o     (wr_ptr),
    .rd_ptr_o     (rd_ptr),
    .full_o       (full),
    .locked_o     (locked),
    .flush_busy_o (flush_busy)
  );
endmodule

// File: rtl/trc_buf_chk.sv
module trc_buf_chk
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_valid_i,
  input logic              reg_write_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [AW-1:0]     wr_ptr,
  input logic [AW-1:0]     rd_ptr,
  input logic              full,
  input logic              locked,
  input logic              flush_busy
);
  // R2
  lock_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && reg_write_i && reg_addr_i == A_LOCK)
      |=> (locked == ($past(reg_wdata_i) != UNLOCK_KEY)));

  // R2
  locked_rdp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && reg_write_i && locked && reg_addr_i == A_RDP) |=> $stable(rd_ptr));

  // R7
  data_read_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !reg_write_i && reg_addr_i == A_DATA)
      |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1)));

  // R4
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_valid_i && reg_write_i && !locked && reg_addr_i == A_WRP)
      |=> (wr_ptr == $past(wr_ptr) || wr_ptr == AW'($past(wr_ptr) + 1'b1)));

  // R6
  full_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full) |-> $past(reg_valid_i && reg_write_i && !locked
                          && reg_addr_i == A_CTRL && reg_wdata_i[0]));

  // R9
  flush_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && reg_write_i && !locked && reg_addr_i == A_FMT && reg_wdata_i[FLUSH_BIT])
      |=> flush_busy);
endmodule

bind trace_buf_top trc_buf_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_trace_buf_top.sv
module sim_trace_buf_top;
  import trc_pkg::*;
  localparam int DEPTH = 16;
  localparam int FLUSH_CYC = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic trc_valid = 1'b0;
  logic [7:0] trc_data = '0;

  trace_buf_top #(.DEPTH(DEPTH), .LANE_W(8), .FLUSH_CYC(FLUSH_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .trc_valid_i(trc_valid), .trc_data_i(trc_data)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_mem [DEPTH];
  int m_wr = 0, m_rd = 0, m_cnt = 0;
  bit m_full = 0, m_en = 0;
  logic [31:0] m_part = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk);
    reg_valid = 0;
    d = reg_rdata;
  endtask

  task automatic expect_rd(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    reg_rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic void model_commit();
    m_mem[m_wr] = m_part;
    if (m_wr == DEPTH - 1) m_full = 1;
    m_wr = (m_wr + 1) % DEPTH;
    m_part = '0;
    m_cnt = 0;
  endfunction

  function automatic void model_byte(logic [7:0] b);
    if (!m_en) return;
    m_part[m_cnt*8 +: 8] = b;
    m_cnt++;
    if (m_cnt == 4) model_commit();
  endfunction

  task automatic push(logic [7:0] b);
    trc_valid = 1; trc_data = b;
    @(negedge clk);
    trc_valid = 0;
    model_byte(b);
  endtask

  task automatic set_en(bit v);
    reg_wr(A_CTRL, {31'b0, v});
    if (v && !m_en) m_full = 0;
    m_en = v;
  endtask

  task automatic do_flush();
    reg_wr(A_FMT, 32'h40);
    if (m_cnt > 0) model_commit();
  endtask

  task automatic drain_check(string req);
    int start, n;
    logic [31:0] v;
    start = m_full ? m_wr : 0;
    n = m_full ? DEPTH : m_wr;
    reg_wr(A_RDP, start);
    m_rd = start;
    for (int i = 0; i < n; i++) begin
      reg_rd(A_DATA, v);
      chk(req, v, m_mem[m_rd]);
      m_rd = (m_rd + 1) % DEPTH;
    end
    expect_rd(req, A_RDP, m_rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int ones, old;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    expect_rd("R1 depth", A_DEPTH, DEPTH);
    expect_rd("R1 status", A_STAT, 0);
    expect_rd("R1 rdp", A_RDP, 0);
    expect_rd("R1 wrp", A_WRP, 0);
    expect_rd("R1 trig", A_TRIG, 0);
    expect_rd("R1 ctrl", A_CTRL, 0);
    expect_rd("R1 fmt", A_FMT, 0);
    expect_rd("R1 lock", A_LSTAT, 3);

    // R2 lock behaviour
    reg_wr(A_RDP, 5);
    expect_rd("R2 locked write ignored", A_RDP, 0);
    reg_wr(A_LOCK, UNLOCK_KEY);
    expect_rd("R2 unlocked status", A_LSTAT, 1);
    reg_wr(A_LOCK, 32'h1234_5678);
    expect_rd("R2 relocked status", A_LSTAT, 3);
    reg_wr(A_TRIG, 32'hAAAA_5555);
    expect_rd("R2 relocked write ignored", A_TRIG, 0);
    reg_wr(A_LOCK, UNLOCK_KEY);

    // R11 formatter bits
    reg_wr(A_FMT, 32'hFFFF_FFBF);
    expect_rd("R11 fmt keep", A_FMT, 32'h0000_0713);
    reg_wr(A_FMT, 0);

    // R8 pointer and trigger registers
    reg_wr(A_RDP, 32'h35);
    expect_rd("R8 rdp mask", A_RDP, 5);
    reg_wr(A_WRP, 32'h1A);
    expect_rd("R8 wrp mask", A_WRP, 32'hA);
    reg_wr(A_TRIG, 32'hDEAD_BEEF);
    expect_rd("R8 trig", A_TRIG, 32'hDEAD_BEEF);
    reg_wr(A_RDP, 0); reg_wr(A_WRP, 0); reg_wr(A_TRIG, 0);

    // R13 unmapped read and hold
    expect_rd("R13 unmapped", 12'h100, 0);
    @(negedge clk);
    chk("R13 hold", reg_rdata, 0);

    // R3 bytes ignored while disabled
    for (int i = 0; i < 4; i++) push(8'hF0 + 8'(i));
    expect_rd("R3 disabled no capture", A_WRP, 0);

    // R3 R4 packing and increment
    set_en(1);
    for (int i = 0; i < 28; i++) push(8'($urandom));
    expect_rd("R4 wrp after words", A_WRP, m_wr);
    set_en(0);
    drain_check("R7 drain");

    // R9 flush with partial word
    set_en(1);
    push(8'hA1); push(8'hB2);
    set_en(0);
    do_flush();
    ones = 0;
    for (int i = 0; i < FLUSH_CYC + 2; i++) begin
      reg_rd(A_FMT, v);
      if (i == 0) chk("R9 busy at start", v[6], 1);
      ones += v[6];
    end
    chk("R9 busy length", ones, FLUSH_CYC);
    expect_rd("R9 wrp after flush", A_WRP, m_wr);
    reg_wr(A_RDP, m_wr - 1);
    expect_rd("R9 padded word", A_DATA, 32'h0000_B2A1);
    do_flush();
    expect_rd("R9 empty flush", A_WRP, m_wr);

    // R10 byte in the flush cycle
    set_en(1);
    push(8'h11);
    trc_valid = 1; trc_data = 8'h22;
    reg_valid = 1; reg_write = 1; reg_addr = A_FMT; reg_wdata = 32'h40;
    @(negedge clk);
    trc_valid = 0; reg_valid = 0; reg_write = 0;
    model_byte(8'h22);
    if (m_cnt > 0) model_commit();
    reg_wr(A_RDP, m_wr - 1);
    expect_rd("R10 flush includes byte", A_DATA, 32'h0000_2211);

    // R5 wrap and sticky full
    while (m_wr != 0) for (int i = 0; i < 4; i++) push(8'($urandom));
    expect_rd("R5 full set", A_STAT, 1);
    reg_wr(A_RDP, 0); reg_wr(A_WRP, 0);
    expect_rd("R5 full after ptr write", A_STAT, 1);
    set_en(0);
    expect_rd("R5 full after disable", A_STAT, 1);
    drain_check("R5 full drain");
    set_en(1);
    expect_rd("R6 full cleared", A_STAT, 0);

    // R12 pointer write with word store
    push(8'h01); push(8'h02); push(8'h03);
    old = m_wr;
    trc_valid = 1; trc_data = 8'h04;
    reg_valid = 1; reg_write = 1; reg_addr = A_WRP; reg_wdata = 32'd3;
    @(negedge clk);
    trc_valid = 0; reg_valid = 0; reg_write = 0;
    model_byte(8'h04);
    m_wr = 3;
    expect_rd("R12 sw wins", A_WRP, 3);
    reg_wr(A_RDP, old);
    expect_rd("R12 word at old ptr", A_DATA, 32'h0403_0201);

    // random traffic
    reg_wr(A_RDP, 0); m_rd = 0;
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 7) push(8'($urandom));
      else if (op == 7) set_en(!m_en);
      else if (op == 8) do_flush();
      else begin
        reg_rd(A_DATA, v);
        chk("R7 random read", v, m_mem[m_rd]);
        m_rd = (m_rd + 1) % DEPTH;
      end
      if (k % 50 == 49) expect_rd("R5 random status", A_STAT, {31'b0, m_full});
    end
    set_en(0);
    do_flush();
    expect_rd("R4 random wrp", A_WRP, m_wr);
    drain_check("R7 final drain");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule